// File: doc/BRIEF.md
# Host Register File with Pointer-Indexed Window

This block is the host-facing register interface of a serial bus controller. A parallel host reaches it through a 2-bit address, 8-bit read and write data, and chip-select, read and write strobes. Four slots are decoded:

| Address | Slot |
|---------|------|
| 0 | Pointer |
| 1 | Reserved |
| 2 | Data window |
| 3 | Control |

Reads and writes on the window act on whichever indirect register the pointer selects. The indirect space holds a transfer byte count and the controller's own bus address.

The control register hands five bits to the bus engine: acknowledge enable, controller enable, START request, STOP request and transfer mode. It also holds an interrupt flag that only hardware can set. The flag is set when the engine reports entry into a state, and it is cleared by any host write to the control register. The interrupt output follows the flag, gated by the enable bit.

In buffered mode the block checks the byte count each time the control register is written. A count out of range raises the interrupt at once. A count in range issues a one-cycle launch pulse to the engine.

Top module: `sbc_host_regfile`

## Requirements
- R1: After reset the pointer and control registers read 00h, the byte count reads 00h, and every control output, the launch pulse and the interrupt are 0. Control bit positions are: 7 acknowledge enable, 6 enable, 5 START, 4 STOP, 3 interrupt flag, 0 mode (1 = buffered).
- R2: Control bits 2:1 always read 0, whatever was written to them.
- R3: A state-entry event with any code other than F8h sets the interrupt flag on the following clock edge. An event carrying F8h leaves the flag unchanged.
- R4: A host write to control address 3 clears the interrupt flag. Writing 1 to bit 3 never sets it.
- R5: The interrupt output is 1 only while both the flag and the enable bit are 1.
- R6: The pointer at address 0 is readable and writable.
- R7: Indirect register 01h (own address) resets to E0h and is read and written through the window at address 2. Its bits 7:1 appear on the own-address output and its bit 0 on the general-call enable output.
- R8: Through the window, an indirect pointer value other than 00h or 01h reads 00h, and writes to it change no register.
- R9: Indirect register 00h (byte count) is read and written through the window. Its bit 7 drives the last-byte output and its bits 6:0 drive the count output.
- R10: A control write with bit 0 = 1 checks count bits 6:0. If they are 0 or above 68, the interrupt flag is set and no launch pulse is issued. Otherwise the launch pulse is high for the one cycle after the write.
- R11: A control write with bit 0 = 0 issues no launch pulse and never sets the flag.
- R12: An engine stop-seen pulse clears the STOP request bit.
- R13: Address 1 reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| eng_state_valid | input | 1 | Engine entered a new state this cycle |
| eng_state_code | input | CODE_W | Code of the state entered |
| eng_stop_seen | input | 1 | Engine detected a STOP condition |
| ctl_ack_en | output | 1 | Acknowledge enable |
| ctl_enable | output | 1 | Controller enable |
| ctl_start | output | 1 | START request |
| ctl_stop | output | 1 | STOP request |
| ctl_buffered | output | 1 | Mode: 1 = buffered |
| buf_count | output | 7 | Byte count |
| buf_last_nack | output | 1 | Last-byte control bit |
| buf_go | output | 1 | One-cycle launch of a buffered transfer |
| own_addr | output | 7 | Own bus address |
| own_gc_en | output | 1 | General-call recognition enable |
| irq_o | output | 1 | Interrupt request |

## Verification
A stuck or wrongly held interrupt flag appears on the very next control-register read, and on the interrupt pin in the cycle after the triggering edge. A wrongly decoded pointer shows up as the wrong value on the next window read. It also shows up as a changed own-address or count output, directly after the write that should have had no effect. The count range check is judged from the launch pulse in the single cycle after the control write and from the flag read just afterwards, so an off-by-one at 0, 68 or 69 is exposed at once.

// File: rtl/sbc_host_pkg.sv
package sbc_host_pkg;
   localparam logic [1:0] SLOT_PTR  = 2'd0;
   localparam logic [1:0] SLOT_RSV  = 2'd1;
   localparam logic [1:0] SLOT_WIN  = 2'd2;
   localparam logic [1:0] SLOT_CTRL = 2'd3;

   localparam int B_ACK   = 7;
   localparam int B_EN    = 6;
   localparam int B_STA   = 5;
   localparam int B_STO   = 4;
   localparam int B_FLAG  = 3;
   localparam int B_MODE  = 0;

   typedef struct packed {
      logic ack_en;
      logic enable;
      logic start;
      logic stop;
      logic flag;
      logic buffered;
   } ctrl_t;
endpackage

// File: rtl/sbc_ctrl_reg.sv
module sbc_ctrl_reg
   import sbc_host_pkg::*;
#(
   parameter int                 CODE_W    = 8,
   parameter logic [CODE_W-1:0]  IDLE_CODE = 8'hF8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   input  logic              evt_valid,
   input  logic [CODE_W-1:0] evt_code,
   input  logic              bad_count_set,
   input  logic              stop_seen,
   output ctrl_t             ctrl,
   output logic [7:0]        rd_val,
   output logic              irq
);
   logic hw_evt;
   logic unused_bits;

   assign hw_evt      = evt_valid && (evt_code != IDLE_CODE);
   assign unused_bits = ^{wdata[2:1], wdata[B_FLAG]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_en) begin
            ctrl.ack_en   <= wdata[B_ACK];
            ctrl.enable   <= wdata[B_EN];
            ctrl.start    <= wdata[B_STA];
            ctrl.buffered <= wdata[B_MODE];
         end
         if (stop_seen)  ctrl.stop <= 1'b0;
         else if (wr_en) ctrl.stop <= wdata[B_STO];
         if (hw_evt || bad_count_set) ctrl.flag <= 1'b1;
         else if (wr_en)              ctrl.flag <= 1'b0;
      end
   end

   always_comb begin
      rd_val         = '0;
      rd_val[B_ACK]  = ctrl.ack_en;
      rd_val[B_EN]   = ctrl.enable;
      rd_val[B_STA]  = ctrl.start;
      rd_val[B_STO]  = ctrl.stop;
      rd_val[B_FLAG] = ctrl.flag;
      rd_val[B_MODE] = ctrl.buffered;
   end

   assign irq = ctrl.flag & ctrl.enable;

   assert_flag_cause_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl.flag) |-> $past(hw_evt || bad_count_set));
   assert_write_clears_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hw_evt && !bad_count_set) |=> !ctrl.flag);
   assert_stop_cleared_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> !ctrl.stop);
endmodule

// File: rtl/sbc_indirect_bank.sv
module sbc_indirect_bank #(
   parameter int         PTR_W     = 8,
   parameter logic [7:0] OWN_RESET = 8'hE0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr,
   input  logic             win_wr,
   input  logic [7:0]       wdata,
   output logic [PTR_W-1:0] ptr,
   output logic [7:0]       win_rd,
   output logic [7:0]       count_q,
   output logic [7:0]       own_q
);
   localparam logic [PTR_W-1:0] IDX_COUNT = PTR_W'(0);
   localparam logic [PTR_W-1:0] IDX_OWN   = PTR_W'(1);

   logic hit_count, hit_own;
   assign hit_count = (ptr == IDX_COUNT);
   assign hit_own   = (ptr == IDX_OWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= '0;
         count_q <= '0;
         own_q   <= OWN_RESET;
      end else begin
         if (ptr_wr)             ptr     <= wdata[PTR_W-1:0];
         if (win_wr && hit_count) count_q <= wdata;
         if (win_wr && hit_own)   own_q   <= wdata;
      end
   end

   always_comb begin
      if (hit_count)    win_rd = count_q;
      else if (hit_own) win_rd = own_q;
      else              win_rd = 8'h00;
   end

   assert_unmapped_inert_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && !ptr_wr && !hit_count && !hit_own) |=> ($stable(count_q) && $stable(own_q)));
endmodule

// File: rtl/sbc_count_check.sv
module sbc_count_check #(
   parameter int MAX_COUNT = 68
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic       wr_buffered,
   input  logic [6:0] count,
   output logic       bad_set,
   output logic       go
);
   localparam logic [6:0] LIMIT = 7'(MAX_COUNT);

   logic in_range;
   assign in_range = (count != 7'd0) && (count <= LIMIT);
   assign bad_set  = ctrl_wr && wr_buffered && !in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go <= 1'b0;
      else        go <= ctrl_wr && wr_buffered && in_range;
   end

   assert_go_legal_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      go |-> $past(ctrl_wr && wr_buffered && count != 7'd0 && count <= LIMIT));
   assert_byte_mode_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wr_buffered) |=> !go);
endmodule

// File: rtl/sbc_host_regfile.sv
module sbc_host_regfile
   import sbc_host_pkg::*;
#(
   parameter int                PTR_W      = 8,
   parameter int                CODE_W     = 8,
   parameter int                MAX_COUNT  = 68,
   parameter logic [7:0]        OWN_RESET  = 8'hE0,
   parameter logic [CODE_W-1:0] IDLE_CODE  = 8'hF8,
   parameter bit                QUIET_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              eng_state_valid,
   input  logic [CODE_W-1:0] eng_state_code,
   input  logic              eng_stop_seen,
   output logic              ctl_ack_en,
   output logic              ctl_enable,
   output logic              ctl_start,
   output logic              ctl_stop,
   output logic              ctl_buffered,
   output logic [6:0]        buf_count,
   output logic              buf_last_nack,
   output logic              buf_go,
   output logic [6:0]        own_addr,
   output logic              own_gc_en,
   output logic              irq_o
);
   initial begin
      assert (PTR_W >= 1 && PTR_W <= 8) else $error("PTR_W out of range");
      assert (MAX_COUNT >= 1 && MAX_COUNT <= 127) else $error("MAX_COUNT out of range");
      assert (CODE_W >= 1) else $error("CODE_W out of range");
   end

   logic             wr_ptr, wr_win, wr_ctrl;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       win_rd, ctrl_rd, count_q, own_q, mux_rd;
   logic             bad_set;
   ctrl_t            ctrl;

   assign wr_ptr  = host_cs && host_wr && (host_addr == SLOT_PTR);
   assign wr_win  = host_cs && host_wr && (host_addr == SLOT_WIN);
   assign wr_ctrl = host_cs && host_wr && (host_addr == SLOT_CTRL);

   sbc_indirect_bank #(.PTR_W(PTR_W), .OWN_RESET(OWN_RESET)) u_bank (
      .clk(clk), .rst_n(rst_n), .ptr_wr(wr_ptr), .win_wr(wr_win),
      .wdata(host_wdata), .ptr(ptr), .win_rd(win_rd),
      .count_q(count_q), .own_q(own_q)
   );

   sbc_count_check #(.MAX_COUNT(MAX_COUNT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
      .wr_buffered(host_wdata[B_MODE]), .count(count_q[6:0]),
      .bad_set(bad_set), .go(buf_go)
   );

   sbc_ctrl_reg #(.CODE_W(CODE_W), .IDLE_CODE(IDLE_CODE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(host_wdata),
      .evt_valid(eng_state_valid), .evt_code(eng_state_code),
      .bad_count_set(bad_set), .stop_seen(eng_stop_seen),
      .ctrl(ctrl), .rd_val(ctrl_rd), .irq(irq_o)
   );

   always_comb begin
      unique case (host_addr)
         SLOT_PTR:  mux_rd = 8'(ptr);
         SLOT_WIN:  mux_rd = win_rd;
         SLOT_CTRL: mux_rd = ctrl_rd;
         default:   mux_rd = 8'h00;
      endcase
   end

   generate
      if (QUIET_READ) begin : g_quiet
         assign host_rdata = (host_cs && host_rd) ? mux_rd : 8'h00;
      end else begin : g_open
         logic unused_rd;
         assign unused_rd  = host_rd;
         assign host_rdata = mux_rd;
      end
   endgenerate

   assign ctl_ack_en    = ctrl.ack_en;
   assign ctl_enable    = ctrl.enable;
   assign ctl_start     = ctrl.start;
   assign ctl_stop      = ctrl.stop;
   assign ctl_buffered  = ctrl.buffered;
   assign buf_count     = count_q[6:0];
   assign buf_last_nack = count_q[7];
   assign own_addr      = own_q[7:1];
   assign own_gc_en     = own_q[0];

   assert_irq_needs_enable_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_enable) |-> !irq_o);
endmodule

// File: tb/tb_sbc_host_regfile.sv
module tb_sbc_host_regfile;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       host_cs = 0, host_rd = 0, host_wr = 0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       eng_state_valid = 0;
   logic [7:0] eng_state_code = '0;
   logic       eng_stop_seen = 0;
   logic       ctl_ack_en, ctl_enable, ctl_start, ctl_stop, ctl_buffered;
   logic [6:0] buf_count, own_addr;
   logic       buf_last_nack, buf_go, own_gc_en, irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic go_s;
   logic [7:0] rv;

   always #10 clk = ~clk;

   sbc_host_regfile dut (
      .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .eng_state_valid(eng_state_valid),
      .eng_state_code(eng_state_code), .eng_stop_seen(eng_stop_seen),
      .ctl_ack_en(ctl_ack_en), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
      .ctl_stop(ctl_stop), .ctl_buffered(ctl_buffered), .buf_count(buf_count),
      .buf_last_nack(buf_last_nack), .buf_go(buf_go), .own_addr(own_addr),
      .own_gc_en(own_gc_en), .irq_o(irq_o)
   );

   typedef struct packed {
      logic       wr;
      logic [1:0] a;
      logic [7:0] d;
      logic [7:0] e;
      logic [7:0] r;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VT [NV] = '{
      '{1'b1, 2'd0, 8'h01, 8'h00, 8'd6},   // R6 pointer -> own address
      '{1'b0, 2'd2, 8'h00, 8'hE0, 8'd7},   // R7 reset value
      '{1'b1, 2'd2, 8'h5A, 8'h00, 8'd7},
      '{1'b0, 2'd2, 8'h00, 8'h5A, 8'd7},
      '{1'b0, 2'd0, 8'h00, 8'h01, 8'd6},   // R6 pointer readback
      '{1'b1, 2'd0, 8'h00, 8'h00, 8'd9},
      '{1'b1, 2'd2, 8'h85, 8'h00, 8'd9},   // R9 count 5, last byte
      '{1'b0, 2'd2, 8'h00, 8'h85, 8'd9},
      '{1'b1, 2'd0, 8'h07, 8'h00, 8'd8},   // R8 unmapped index
      '{1'b0, 2'd2, 8'h00, 8'h00, 8'd8},
      '{1'b1, 2'd2, 8'hFF, 8'h00, 8'd8},
      '{1'b0, 2'd2, 8'h00, 8'h00, 8'd8},
      '{1'b0, 2'd1, 8'h00, 8'h00, 8'd13},  // R13 reserved slot
      '{1'b1, 2'd0, 8'h01, 8'h00, 8'd8},
      '{1'b0, 2'd2, 8'h00, 8'h5A, 8'd8},   // R8 own address untouched
      '{1'b1, 2'd0, 8'h00, 8'h00, 8'd8},
      '{1'b0, 2'd2, 8'h00, 8'h85, 8'd8},   // R8 count untouched
      '{1'b1, 2'd3, 8'hFE, 8'h00, 8'd2},
      '{1'b0, 2'd3, 8'h00, 8'hF0, 8'd2}    // R2 reserved zero, R4 no set
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
      @(posedge clk);
      @(negedge clk);
      host_cs = 0; host_wr = 0;
      go_s = buf_go;
   endtask

   task automatic hread(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      host_cs = 1; host_rd = 1; host_addr = a;
      #2;
      v = host_rdata;
      host_cs = 0; host_rd = 0;
   endtask

   task automatic state_evt(input logic [7:0] code);
      @(negedge clk);
      eng_state_valid = 1; eng_state_code = code;
      @(posedge clk);
      @(negedge clk);
      eng_state_valid = 0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(20 * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      hread(2'd0, rv); chk("R1 pointer", rv, 8'h00);
      hread(2'd3, rv); chk("R1 control", rv, 8'h00);
      hread(2'd2, rv); chk("R1 count", rv, 8'h00);
      chk("R1 outputs", {ctl_ack_en, ctl_enable, ctl_start, ctl_stop, ctl_buffered, buf_go, irq_o, 1'b0}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         if (VT[i].wr) hwrite(VT[i].a, VT[i].d);
         else begin
            hread(VT[i].a, rv);
            n_tests++;
            if (rv !== VT[i].e) begin
               n_fail++;
               $display("FAIL R%0d row %0d actual=%02h expected=%02h", VT[i].r, i, rv, VT[i].e);
            end
         end
      end

      chk("R7 own outputs", {own_addr, own_gc_en}, 8'h5A);
      chk("R9 count outputs", {buf_last_nack, buf_count}, 8'h85);
      chk("R1 control outputs", {3'b0, ctl_ack_en, ctl_enable, ctl_start, ctl_stop, ctl_buffered}, 8'h1E);

      // R12 stop seen
      @(negedge clk); eng_stop_seen = 1;
      @(negedge clk); eng_stop_seen = 0;
      chk("R12 stop port", {7'b0, ctl_stop}, 8'h00);
      hread(2'd3, rv); chk("R12 control", rv, 8'hE0);

      // R3 / R4 / R5 flag behaviour
      hwrite(2'd3, 8'h40);
      state_evt(8'hF8);
      hread(2'd3, rv); chk("R3 idle code", rv, 8'h40);
      chk("R5 no irq", {7'b0, irq_o}, 8'h00);
      state_evt(8'h08);
      hread(2'd3, rv); chk("R3 state entry", rv, 8'h48);
      chk("R5 irq", {7'b0, irq_o}, 8'h01);
      hwrite(2'd3, 8'h40);
      hread(2'd3, rv); chk("R4 clear", rv, 8'h40);
      chk("R5 irq cleared", {7'b0, irq_o}, 8'h00);
      hwrite(2'd3, 8'h48);
      hread(2'd3, rv); chk("R4 no host set", rv, 8'h40);
      hwrite(2'd3, 8'h00);
      state_evt(8'h10);
      hread(2'd3, rv); chk("R3 disabled entry", rv, 8'h08);
      chk("R5 gated", {7'b0, irq_o}, 8'h00);

      // R10 buffered count checks (pointer still 00h)
      hwrite(2'd2, 8'h00);
      hwrite(2'd3, 8'h41); chk("R10 zero go", {7'b0, go_s}, 8'h00);
      hread(2'd3, rv); chk("R10 zero flag", rv, 8'h49);
      chk("R10 zero irq", {7'b0, irq_o}, 8'h01);
      hwrite(2'd2, 8'h44);
      hwrite(2'd3, 8'h41); chk("R10 max go", {7'b0, go_s}, 8'h01);
      hread(2'd3, rv); chk("R10 max flag", rv, 8'h41);
      hwrite(2'd2, 8'h45);
      hwrite(2'd3, 8'h41); chk("R10 over go", {7'b0, go_s}, 8'h00);
      hread(2'd3, rv); chk("R10 over flag", rv, 8'h49);
      hwrite(2'd2, 8'hC5);
      hwrite(2'd3, 8'h41); chk("R10 over lb go", {7'b0, go_s}, 8'h00);
      hwrite(2'd2, 8'h81);
      hwrite(2'd3, 8'h41); chk("R10 one go", {7'b0, go_s}, 8'h01);
      hread(2'd3, rv); chk("R10 one flag", rv, 8'h41);
      chk("R9 last byte", {buf_last_nack, buf_count}, 8'h81);
      @(negedge clk);
      chk("R10 single pulse", {7'b0, buf_go}, 8'h00);

      // R11 byte mode ignores count
      hwrite(2'd2, 8'h00);
      hwrite(2'd3, 8'h40); chk("R11 go", {7'b0, go_s}, 8'h00);
      hread(2'd3, rv); chk("R11 flag", rv, 8'h40);

      summary();
      $finish;
   end
endmodule